// File: doc/BRIEF.md
# FIFO Buffer with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer whose depth is a parameter (256 words by default). It has a write port and a read port, each with its own clock and its own active-low enable. A word moves into the registered output only when the reader asks for it. Nothing falls through on its own.

Five active-low status flags report the fill level:
- full and empty;
- a half-full flag that asserts only above the midpoint;
- an almost-full flag and an almost-empty flag. Their thresholds come in as two 12-bit offsets, driven by a separate offset register block. An offset can change while the buffer holds data, and the flag follows at once.

An active-low select input, high in normal operation, holds off all buffer traffic while the offset block is being accessed. A parameter selects the clocking. With the clocks tied, the two pointers are compared directly. With independent clocks, each pointer crosses to the other domain in Gray code through a two-stage synchroniser.

Top module: `sync_fifo_flags`

## Requirements
- R1: With `wen_n` low and `prog_n` high, a rising write clock stores `din` when fewer than DEPTH words are held. Words come out in the order they were written.
- R2: With DEPTH words held, a write request is dropped. The count stays at DEPTH and the stored data is unchanged.
- R3: With `ren_n` low and `prog_n` high, and at least one word held, a rising read clock loads the oldest word into `dout`. `dout` changes only on such a read; a word written into an empty buffer does not appear until it is read.
- R4: With zero words held, a read request is dropped and `dout` keeps its value. A read and a write on the same edge into an empty buffer store the word without reading it.
- R5: An active-low `rst_n` empties the buffer and clears `dout` to zero. After reset, `full_n`, `half_n` and `afull_n` are high, and `empty_n` and `aempty_n` are low.
- R6: `empty_n` is low exactly when the count is 0.
- R7: `aempty_n` is low exactly when the count is at most `empty_ofs`.
- R8: `afull_n` is low exactly when the count is at least DEPTH minus `full_ofs`.
- R9: `half_n` is low exactly when the count is greater than DEPTH/2.
- R10: While `prog_n` is low, neither a write nor a read takes place, whatever the enables are.
- R11: `full_n` is low exactly when the count equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| prog_n | input | 1 | Offset access select, active low; blocks buffer traffic while low |
| din | input | 18 | Write data |
| empty_ofs | input | 12 | Almost-empty threshold n |
| full_ofs | input | 12 | Almost-full threshold m |
| dout | output | 18 | Registered read data |
| full_n | output | 1 | Full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| half_n | output | 1 | Above-half flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |

## Verification
The bench goes after each flag boundary one word either side:
- A design with an off-by-one compare would move a threshold flag one word early or late.
- A design that fired half-full at exactly DEPTH/2 words would fail at the midpoint.

It writes past full and reads past empty:
- Overwriting the oldest word would corrupt the data later drained.
- A pointer that wrapped would show up in the counts and data that follow.
- Reloading the output register on an empty read would change `dout`.

Further cases:
- A simultaneous read and write on an empty buffer catches a design that lets the new word fall through.
- Traffic with `prog_n` low catches a design that ignores the select.
- Moving the offsets while the buffer holds data catches thresholds that are latched instead of compared live.

// File: rtl/sync_fifo_flags.sv
module sync_fifo_flags #(
  parameter int DW = 18,
  parameter int DEPTH = 256,
  parameter int OW = 12,
  parameter bit DUAL_CLOCK = 1'b0
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wen_n,
  input  logic          ren_n,
  input  logic          prog_n,
  input  logic [DW-1:0] din,
  input  logic [OW-1:0] empty_ofs,
  input  logic [OW-1:0] full_ofs,
  output logic [DW-1:0] dout,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_n,
  output logic          afull_n,
  output logic          aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = ((PW > OW) ? PW : OW) + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr, rptr_w, wptr_r;
  logic [PW-1:0] wcnt, rcnt;
  logic          do_wr, do_rd;

  assign wcnt  = wptr - rptr_w;
  assign rcnt  = wptr_r - rptr;
  assign do_wr = !wen_n && prog_n && (wcnt != PW'(DEPTH));
  assign do_rd = !ren_n && prog_n && (rcnt != '0);

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) wptr <= '0;
    else if (do_wr) wptr <= wptr + 1'b1;

  always_ff @(posedge wclk)
    if (do_wr) mem[wptr[AW-1:0]] <= din;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rptr <= '0;
      dout <= '0;
    end else if (do_rd) begin
      rptr <= rptr + 1'b1;
      dout <= mem[rptr[AW-1:0]];
    end

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  generate
    if (DUAL_CLOCK) begin : g_async
      logic [PW-1:0] wg_q, rg_q, wg_s1, wg_s2, rg_s1, rg_s2, wnext, rnext;
      assign wnext = wptr + PW'(do_wr);
      assign rnext = rptr + PW'(do_rd);
      always_ff @(posedge wclk or negedge rst_n)
        if (!rst_n) {wg_q, rg_s2, rg_s1} <= '0;
        else        {wg_q, rg_s2, rg_s1} <= {wnext ^ (wnext >> 1), rg_s1, rg_q};
      always_ff @(posedge rclk or negedge rst_n)
        if (!rst_n) {rg_q, wg_s2, wg_s1} <= '0;
        else        {rg_q, wg_s2, wg_s1} <= {rnext ^ (rnext >> 1), wg_s1, wg_q};
      assign rptr_w = gray2bin(rg_s2);
      assign wptr_r = gray2bin(wg_s2);
    end else begin : g_sync
      assign rptr_w = rptr;
      assign wptr_r = wptr;
    end
  endgenerate

  assign full_n   = (wcnt != PW'(DEPTH));
  assign half_n   = !(wcnt > PW'(DEPTH / 2));
  assign afull_n  = (CW'(wcnt) + CW'(full_ofs)) < CW'(DEPTH);
  assign empty_n  = (rcnt != '0);
  assign aempty_n = CW'(rcnt) > CW'(empty_ofs);

  // R2
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wptr));
  // R4
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(dout));
  // R3
  dout_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    ren_n |=> $stable(dout));
  // R10
  prog_block_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !prog_n |=> $stable(wptr));
  // R8
  full_implies_afull_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> (!afull_n && !half_n));
  // R7
  empty_implies_aempty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
endmodule

// File: tb/sim_sync_fifo_flags.sv
module sim_sync_fifo_flags;
  localparam int D = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0, wen_n = 1'b1, ren_n = 1'b1, prog_n = 1'b1;
  logic [17:0] din = '0;
  logic [11:0] empty_ofs = 12'd3, full_ofs = 12'd4;
  logic [17:0] dout;
  logic full_n, empty_n, half_n, afull_n, aempty_n;
  int total = 0, fails = 0;
  bit done = 0;
  logic [17:0] mq[$];
  logic [17:0] expd = '0;

  always #5 clk = ~clk;

  sync_fifo_flags #(.DW(18), .DEPTH(D), .OW(12), .DUAL_CLOCK(1'b0)) u0 (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .wen_n(wen_n), .ren_n(ren_n),
    .prog_n(prog_n), .din(din), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .dout(dout), .full_n(full_n), .empty_n(empty_n), .half_n(half_n),
    .afull_n(afull_n), .aempty_n(aempty_n));

  localparam logic [20:0] VEC [20] = '{
    {3'b011, 18'h00A01}, {3'b011, 18'h00A02}, {3'b011, 18'h00A03}, {3'b011, 18'h00A04},
    {3'b101, 18'h00000}, {3'b001, 18'h00B05}, {3'b011, 18'h00B06}, {3'b011, 18'h00B07},
    {3'b011, 18'h00B08}, {3'b011, 18'h00B09}, {3'b011, 18'h00B0A}, {3'b011, 18'h00B0B},
    {3'b111, 18'h3FFFF}, {3'b011, 18'h00C0C}, {3'b011, 18'h00C0D}, {3'b011, 18'h00C0E},
    {3'b101, 18'h00000}, {3'b101, 18'h00000}, {3'b001, 18'h00C0F}, {3'b111, 18'h00000}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h count=%0d", tag, act, exp, mq.size());
    end
  endtask

  task automatic chk_all(input string dtag);
    int c;
    c = mq.size();
    chk(32'(dout), 32'(expd), dtag);
    chk(32'(full_n), 32'(c != D), "R11 full");
    chk(32'(empty_n), 32'(c != 0), "R6 empty");
    chk(32'(aempty_n), 32'(c > int'(empty_ofs)), "R7 almost-empty");
    chk(32'(afull_n), 32'(c < D - int'(full_ofs)), "R8 almost-full");
    chk(32'(half_n), 32'(c <= D / 2), "R9 half");
  endtask

  task automatic step(input logic w, input logic r, input logic p,
                      input logic [17:0] d, input string tag);
    bit dw, dr;
    wen_n = w; ren_n = r; prog_n = p; din = d;
    @(posedge clk);
    dw = !w && p && (mq.size() < D);
    dr = !r && p && (mq.size() > 0);
    if (dr) expd = mq.pop_front();
    if (dw) mq.push_back(d);
    @(negedge clk);
    chk_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wen_n = 1'b1; ren_n = 1'b1; prog_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    mq.delete();
    expd = '0;
    chk_all("R5 reset dout");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R5: flags and output right after reset
    chk(32'(full_n & half_n & afull_n), 32'd1, "R5 high flags");
    chk(32'(empty_n | aempty_n), 32'd0, "R5 low flags");
    // R1 R3: table walk
    for (int i = 0; i < 20; i++)
      step(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17:0], "R1 R3 data");
    // R2: fill past full, then check data order
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, 18'h10 + 18'(i), "R2 overfill");
    step(1'b0, 1'b0, 1'b1, 18'h3AAAA, "R2 read while full");
    // R10: traffic while offset access selected
    step(1'b0, 1'b0, 1'b0, 18'h3BBBB, "R10 blocked");
    step(1'b1, 1'b0, 1'b0, 18'h0, "R10 blocked read");
    // R7 R8: move offsets with data held
    empty_ofs = 12'd15; full_ofs = 12'd1;
    step(1'b1, 1'b1, 1'b1, 18'h0, "R8 offset change");
    // R4: drain past empty
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b1, 18'h0, "R4 overdrain");
    empty_ofs = 12'd0; full_ofs = 12'd0;
    // R4 R3: simultaneous read and write on empty, no fall-through
    step(1'b0, 1'b0, 1'b1, 18'h2C0DE, "R4 R3 empty rw");
    step(1'b1, 1'b1, 1'b1, 18'h0, "R3 no fall-through");
    step(1'b1, 1'b0, 1'b1, 18'h0, "R3 first word read");
    // R9: walk the midpoint one word at a time
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, 18'h500 + 18'(i), "R9 ramp");
    // R5: reset with data held
    do_reset();
    step(1'b1, 1'b0, 1'b1, 18'h0, "R5 read after reset");
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule